// File: doc/BRIEF.md
# APB Peripheral Address Decoder

This block sits on the APB side of an AHB-to-APB bridge. It takes the bridge's 32-bit APB transfer and turns the address into one select line for one of ten peripherals: boot ROM, GPIO, two serial ports, SPI, two general timers, a fast timer, a watchdog and a system control block. Each peripheral owns an aligned 4 KiB window above a shared base address. The decoder routes the selected peripheral's ready and read data back to the bridge. Before returning read data it masks it to that peripheral's data width: 8 bits for the serial ports, 16 bits for SPI and 32 bits for the rest.

When an address falls outside every window, no peripheral is selected. The decoder then completes the transfer itself in its first ACCESS cycle, so the bus cannot stall, and raises a one-cycle fast-interrupt request. A write to such an address reaches no peripheral. A read returns a value that software must treat as undefined.

The decoder does not check access widths. A narrow write to a wide register is forwarded unchanged. The error response line is held low, because faults are reported only through the interrupt.

Top module: `apb_periph_decoder`

## Requirements
- R1: An address whose bits [31:16] equal the base (0x4000) and whose bits [15:12] hold index i < 10 asserts `periph_sel[i]` alone while `psel` is high. The indices map as follows: 0 boot ROM, 1 GPIO, 2 serial 0, 3 serial 1, 4 SPI, 5 timer 0, 6 timer 1, 7 fast timer, 8 watchdog, 9 system control. At no time is more than one select high.
- R2: While `psel` is low, every `periph_sel` bit is low, whatever the address.
- R3: An address with index 10 to 15 or a different base asserts no `periph_sel`, and `pready` is high in the first ACCESS cycle.
- R4: `fiq_req` is high for exactly one cycle, the first ACCESS cycle of an unmapped transfer, and is low in every other cycle.
- R5: `pslverr` is low on every transfer.
- R6: For a mapped transfer, `pready` follows the selected peripheral's ready, so peripheral wait states lengthen the ACCESS phase one cycle each.
- R7: Read data from the serial windows (2, 3) keeps bits [7:0] with the rest zero. Read data from SPI (4) keeps bits [15:0] with the rest zero. All other windows pass 32 bits unchanged.
- R8: A write to an unmapped address leaves every peripheral's stored contents unchanged.
- R9: After reset, `fiq_req`, `pready` and all `periph_sel` bits are low while the bus is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | APB clock |
| rst_n | input | 1 | Synchronous active-low reset |
| paddr | input | 32 | APB address |
| psel | input | 1 | APB select from the bridge |
| penable | input | 1 | APB enable (ACCESS phase) |
| periph_ready | input | 10 | Ready from each peripheral |
| periph_rdata | input | 320 | Read data from each peripheral, 32 bits each, index 0 lowest |
| periph_sel | output | 10 | One-hot peripheral select |
| periph_offset | output | 12 | Offset inside the 4 KiB window |
| pready | output | 1 | Ready returned to the bridge |
| prdata | output | 32 | Read data returned to the bridge |
| pslverr | output | 1 | Error response, held low |
| fiq_req | output | 1 | Fast-interrupt pulse on an unmapped access |

## Verification
Every one of the ten windows is read at its reset value, then written and read back. Each window's stub peripheral inserts a different number of wait states (0, 1 or 2). This separates a wrong index decode from a wrong ready path, and it shows whether the width mask follows the correct window. Unmapped patterns cover a high in-base index, the top index and a foreign base. Each checks the select lines, the one-cycle ready and the interrupt pulse, and a full read-back afterwards shows that no unmapped write leaked into a peripheral. An idle bus carrying a mapped address tells select gating apart from address decoding.

// File: rtl/apb_dec_pkg.sv
// Package: peripheral numbering and per-window data width for the APB decoder.
package apb_dec_pkg;
    localparam int unsigned PERI_COUNT = 10;

    typedef enum logic [3:0] {
        PERI_BOOTROM = 4'd0,
        PERI_GPIO    = 4'd1,
        PERI_SER0    = 4'd2,
        PERI_SER1    = 4'd3,
        PERI_SPI     = 4'd4,
        PERI_TMR0    = 4'd5,
        PERI_TMR1    = 4'd6,
        PERI_FTMR    = 4'd7,
        PERI_WDOG    = 4'd8,
        PERI_SYSCTL  = 4'd9
    } periph_e;

    // Data width in bits served by the peripheral at a given window index.
    function automatic int unsigned periph_width(input int unsigned idx);
        case (idx)
            int'(PERI_SER0), int'(PERI_SER1): return 8;
            int'(PERI_SPI):                   return 16;
            default:                          return 32;
        endcase
    endfunction
endpackage

// File: rtl/apb_region_decode.sv
// Region decoder: compares the upper address tag with the base and turns the
// window index into a one-hot select. Assumes aligned windows of 2**WIN_BITS.
module apb_region_decode #(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned WIN_BITS = 12,
    parameter int unsigned IDX_W    = 4,
    parameter int unsigned NUM_PERI = 10,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h4000_0000
) (
    input  logic [ADDR_W-1:WIN_BITS] addr_hi,
    input  logic                     req,
    output logic [NUM_PERI-1:0]      sel_vec,
    output logic                     hit
);
    localparam int unsigned TAG_LSB = WIN_BITS + IDX_W;

    logic             tag_ok;
    logic [IDX_W-1:0] idx;

    // Tag match and window index extraction.
    always_comb begin
        tag_ok = (addr_hi[ADDR_W-1:TAG_LSB] == BASE_ADDR[ADDR_W-1:TAG_LSB]);
        idx    = addr_hi[TAG_LSB-1:WIN_BITS];
        hit    = tag_ok && (32'(idx) < NUM_PERI);
    end

    // One select per window, gated by the bus request.
    for (genvar g = 0; g < NUM_PERI; g++) begin : g_sel
        assign sel_vec[g] = req && tag_ok && (idx == IDX_W'(g));
    end
endmodule

// File: rtl/apb_resp_mux.sv
// Response mux: returns ready and width-masked read data of the selected
// peripheral. Assumes sel_vec is one-hot or zero; zero selection gives zeros.
module apb_resp_mux #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_PERI = 10
) (
    input  logic [NUM_PERI-1:0]        sel_vec,
    input  logic [NUM_PERI-1:0]        ready_vec,
    input  logic [NUM_PERI*DATA_W-1:0] rdata_flat,
    output logic                       ready,
    output logic [DATA_W-1:0]          rdata
);
    logic [DATA_W-1:0] masked [NUM_PERI];

    // Per-window mask sized from the peripheral's data width.
    for (genvar g = 0; g < NUM_PERI; g++) begin : g_mask
        localparam int unsigned PW = apb_dec_pkg::periph_width(g);
        localparam logic [DATA_W-1:0] MASK =
            (PW >= DATA_W) ? {DATA_W{1'b1}} : ((DATA_W'(1) << PW) - DATA_W'(1));
        assign masked[g] = rdata_flat[g*DATA_W +: DATA_W] & MASK;
    end

    // AND-OR selection of the active peripheral's response.
    always_comb begin
        ready = 1'b0;
        rdata = '0;
        for (int i = 0; i < int'(NUM_PERI); i++) begin
            if (sel_vec[i]) begin
                ready = ready | ready_vec[i];
                rdata = rdata | masked[i];
            end
        end
    end
endmodule

// File: rtl/apb_unmapped_ctrl.sv
// Unmapped-access handler: closes a transfer that hits no window and raises a
// one-cycle interrupt in its ACCESS cycle. Assumes APB SETUP precedes ACCESS.
module apb_unmapped_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic psel,
    input  logic penable,
    input  logic hit,
    output logic local_ready,
    output logic fiq_req
);
    logic fiq_q;

    // Arm the interrupt in SETUP so it is high during the single ACCESS cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) fiq_q <= 1'b0;
        else        fiq_q <= psel && !penable && !hit;
    end

    // Decoder-generated ready for transfers no peripheral answers.
    assign local_ready = psel && penable && !hit;
    assign fiq_req     = fiq_q;
endmodule

// File: rtl/apb_periph_decoder.sv
// APB peripheral address decoder top: selects one of NUM_PERI peripherals,
// returns its ready and read data, and closes unmapped transfers with an
// interrupt pulse. Assumes address, select and enable come from one bridge.
module apb_periph_decoder #(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned WIN_BITS = 12,
    parameter int unsigned IDX_W    = 4,
    parameter int unsigned NUM_PERI = apb_dec_pkg::PERI_COUNT,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h4000_0000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          paddr,
    input  logic                       psel,
    input  logic                       penable,
    input  logic [NUM_PERI-1:0]        periph_ready,
    input  logic [NUM_PERI*DATA_W-1:0] periph_rdata,
    output logic [NUM_PERI-1:0]        periph_sel,
    output logic [WIN_BITS-1:0]        periph_offset,
    output logic                       pready,
    output logic [DATA_W-1:0]          prdata,
    output logic                       pslverr,
    output logic                       fiq_req
);
    logic hit;
    logic mux_ready;
    logic local_ready;

    apb_region_decode #(
        .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .IDX_W(IDX_W),
        .NUM_PERI(NUM_PERI), .BASE_ADDR(BASE_ADDR)
    ) dec_i (
        .addr_hi (paddr[ADDR_W-1:WIN_BITS]),
        .req     (psel),
        .sel_vec (periph_sel),
        .hit     (hit)
    );

    apb_resp_mux #(.DATA_W(DATA_W), .NUM_PERI(NUM_PERI)) mux_i (
        .sel_vec    (periph_sel),
        .ready_vec  (periph_ready),
        .rdata_flat (periph_rdata),
        .ready      (mux_ready),
        .rdata      (prdata)
    );

    apb_unmapped_ctrl miss_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .psel        (psel),
        .penable     (penable),
        .hit         (hit),
        .local_ready (local_ready),
        .fiq_req     (fiq_req)
    );

    // Combine peripheral and decoder ready; errors go out only by interrupt.
    assign pready        = mux_ready || local_ready;
    assign pslverr       = 1'b0;
    assign periph_offset = paddr[WIN_BITS-1:0];
endmodule

// File: rtl/apb_dec_checker.sv
// Checker: bus-level properties of the APB decoder, bound to the top module.
module apb_dec_checker #(
    parameter int unsigned NUM_PERI = 10
) (
    input logic                clk,
    input logic                rst_n,
    input logic                psel,
    input logic                penable,
    input logic [NUM_PERI-1:0] periph_sel,
    input logic [NUM_PERI-1:0] periph_ready,
    input logic                pready,
    input logic                fiq_req
);
    p_sel_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(periph_sel));

    p_idle_nosel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !psel |-> (periph_sel == '0));

    p_unmapped_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && (periph_sel == '0)) |-> pready);

    p_fiq_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_req |=> !fiq_req);

    p_fiq_in_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_req |-> (psel && penable && (periph_sel == '0)));

    p_wait_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && ((periph_sel & ~periph_ready) != '0)) |-> !pready);
endmodule

bind apb_periph_decoder apb_dec_checker #(.NUM_PERI(NUM_PERI)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .psel         (psel),
    .penable      (penable),
    .periph_sel   (periph_sel),
    .periph_ready (periph_ready),
    .pready       (pready),
    .fiq_req      (fiq_req)
);

// File: tb/apb_periph_decoder_tb.sv
// Scoreboard bench: the driver queues expected read data, a monitor compares.
module apb_periph_decoder_tb_top;
    localparam int NP = 10;
    localparam logic [31:0] BASE = 32'h4000_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [31:0] paddr = '0;
    logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [31:0] pwdata = '0;
    logic [NP-1:0] periph_ready;
    logic [NP*32-1:0] periph_rdata;
    logic [NP-1:0] periph_sel;
    logic [11:0] periph_offset;
    logic pready, pslverr, fiq_req;
    logic [31:0] prdata;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    typedef struct { bit chk; logic [31:0] val; } exp_t;
    exp_t sb_q[$];

    logic [31:0] stub_reg [NP];
    int          stub_cnt [NP];
    logic [31:0] model    [NP];

    always #4 clk = ~clk;

    apb_periph_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .paddr(paddr), .psel(psel), .penable(penable),
        .periph_ready(periph_ready), .periph_rdata(periph_rdata),
        .periph_sel(periph_sel), .periph_offset(periph_offset), .pready(pready),
        .prdata(prdata), .pslverr(pslverr), .fiq_req(fiq_req)
    );

    // Peripheral stubs: one register each, i%3 wait states.
    always_comb begin
        for (int i = 0; i < NP; i++) begin
            periph_ready[i] = periph_sel[i] && penable && (stub_cnt[i] == i % 3);
            periph_rdata[i*32 +: 32] = stub_reg[i];
        end
    end

    always @(posedge clk) begin
        for (int i = 0; i < NP; i++) begin
            if (!rst_n) begin
                stub_reg[i] <= 32'hC3A5_0000 | i;
                stub_cnt[i] <= 0;
            end else if (periph_sel[i] && penable) begin
                if (periph_ready[i]) begin
                    stub_cnt[i] <= 0;
                    if (pwrite) stub_reg[i] <= pwdata;
                end else begin
                    stub_cnt[i] <= stub_cnt[i] + 1;
                end
            end
        end
    end

    function automatic logic [31:0] width_mask(input int idx);
        if (idx == 2 || idx == 3) return 32'h0000_00FF;
        if (idx == 4)             return 32'h0000_FFFF;
        return 32'hFFFF_FFFF;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: compares completed reads against the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n && psel && penable && pready && !pwrite) begin
            exp_t e;
            if (sb_q.size() == 0) begin
                check(1'b0, "R7 unexpected read", prdata, 32'h0);
            end else begin
                e = sb_q.pop_front();
                if (e.chk) check(prdata === e.val, "R7 read data", prdata, e.val);
            end
        end
    end

    // Driver: one APB transfer; idx = -1 for an unmapped address.
    task automatic xfer(input logic [31:0] addr, input bit wr,
                        input logic [31:0] data, input int idx);
        exp_t e;
        int waits;
        logic [NP-1:0] exp_sel;
        exp_sel = (idx >= 0) ? NP'(1) << idx : '0;
        @(posedge clk); #1;
        paddr = addr; psel = 1'b1; penable = 1'b0; pwrite = wr; pwdata = data;
        if (!wr) begin
            e.chk = (idx >= 0);
            e.val = (idx >= 0) ? (model[idx] & width_mask(idx)) : 32'h0;
            sb_q.push_back(e);
        end
        @(negedge clk);
        check(periph_sel === exp_sel, (idx >= 0) ? "R1 select" : "R3 no select",
              32'(periph_sel), 32'(exp_sel));
        @(posedge clk); #1;
        penable = 1'b1;
        waits = 0;
        @(negedge clk);
        check(fiq_req === (idx < 0), "R4 fiq in access", 32'(fiq_req), 32'(idx < 0));
        while (pready !== 1'b1) begin
            waits++;
            @(negedge clk);
        end
        check(waits == ((idx >= 0) ? idx % 3 : 0), (idx >= 0) ? "R6 wait states" : "R3 ready",
              32'(waits), 32'((idx >= 0) ? idx % 3 : 0));
        check(pslverr === 1'b0, "R5 pslverr", 32'(pslverr), 32'h0);
        @(posedge clk); #1;
        psel = 1'b0; penable = 1'b0;
        if (wr && idx >= 0) model[idx] = data;
        if (idx < 0) begin
            @(negedge clk);
            check(fiq_req === 1'b0, "R4 fiq one cycle", 32'(fiq_req), 32'h0);
        end
    endtask

    initial begin
        for (int i = 0; i < NP; i++) model[i] = 32'hC3A5_0000 | i;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(fiq_req === 1'b0, "R9 fiq reset", 32'(fiq_req), 32'h0);
        check(pready === 1'b0, "R9 pready reset", 32'(pready), 32'h0);
        check(periph_sel === '0, "R9 sel reset", 32'(periph_sel), 32'h0);

        // R2: idle bus with a mapped address selects nothing.
        @(posedge clk); #1 paddr = BASE | 32'h0000_5000;
        @(negedge clk);
        check(periph_sel === '0, "R2 idle no select", 32'(periph_sel), 32'h0);

        // R1/R6/R7: reset value reads, then write and read back per window.
        for (int i = 0; i < NP; i++) xfer(BASE + (i << 12) + 32'h10, 1'b0, '0, i);
        for (int i = 0; i < NP; i++)
            xfer(BASE + (i << 12) + 32'h4, 1'b1, 32'h9E37_79B9 ^ (32'h0101_0101 * i), i);
        for (int i = 0; i < NP; i++) xfer(BASE + (i << 12) + 32'h8, 1'b0, '0, i);

        // R3/R4/R8: unmapped writes and reads.
        xfer(BASE | 32'h0000_A000, 1'b1, 32'hDEAD_BEEF, -1);
        xfer(BASE | 32'h0000_F004, 1'b1, 32'h1234_5678, -1);
        xfer(32'h5000_1000,        1'b1, 32'hFFFF_FFFF, -1);
        xfer(BASE | 32'h0000_B000, 1'b0, '0, -1);

        // R8: every peripheral still holds its last mapped write.
        for (int i = 0; i < NP; i++) xfer(BASE + (i << 12), 1'b0, '0, i);

        repeat (2) @(negedge clk);
        check(sb_q.size() == 0, "R7 all reads seen", 32'(sb_q.size()), 32'h0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule